// File: doc/BRIEF.md
# Frame Character Down-Counter

This block keeps count of how many characters are still to come in the current frame or message, for one direction of a serial channel. Software writes a starting count into a limit register. The counter copies that limit when a frame starts, or when a load command arrives. After that it steps down by one for every character that passes between the FIFO and the serializer.

On the character that takes the count from 1 to 0, the block raises an end tag in the same cycle as that character's strobe. The FIFO stores this tag with the character as its end-of-frame or end-of-message mark. A limit of zero leaves the counter switched off. If the frame ends early, the count still outstanding is kept so that the actual frame length can be worked out.

One instance serves each direction. On the receive side the live count is hidden from readout.

Top module: `frame_char_counter`

## Requirements
- R1: A write with `lim_we_i` high stores `lim_wdata_i`. A load copies the stored limit to `count_o` on the next clock edge. A load is `frame_start_i` high, or `cmd_i` = 2'b01.
- R2: A load sets `en_o` to 1 when the limit is nonzero and to 0 when the limit is zero. While `en_o` is 0, strobes do not change the count and never raise the tag.
- R3: A `char_stb_i` cycle with `en_o` high, a nonzero count, and no load or clear lowers `count_o` by one at the next edge.
- R4: `eof_tag_o` is high during the strobe cycle in which the count is 1 and the counter is enabled, so that character is marked as the end of the frame.
- R5: At a count of 0, further strobes leave the count at 0 and do not raise the tag. The counter does not wrap.
- R6: When a load and a strobe arrive in the same cycle, the load wins. The count takes the limit and the tag stays low.
- R7: `cmd_i` = 2'b10 (clear) sets both the count and `en_o` to 0. `cmd_i` = 2'b11 (FIFO purge) leaves the count and `en_o` unchanged. `cmd_i` = 2'b00 does nothing.
- R8: `frame_end_i` in a cycle with `en_o` high and a nonzero count stores that cycle's count (before any decrement) into `resid_o` and sets `resid_vld_o` at the next edge. A load or a clear sets `resid_vld_o` back to 0.
- R9: With parameter `READ_EN` = 0, which is the receive-side build, `count_o` always reads 0. Counting, tagging and the residual still work.
- R10: While `rst_ni` is low, `count_o`, `en_o`, `eof_tag_o` and `resid_vld_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lim_we_i | input | 1 | Write strobe for the limit register |
| lim_wdata_i | input | CNT_W | Value written to the limit register |
| cmd_i | input | 2 | Command: 00 none, 01 load, 10 clear, 11 FIFO purge |
| frame_start_i | input | 1 | Frame start; loads the limit into the counter |
| char_stb_i | input | 1 | One character handled in this direction |
| frame_end_i | input | 1 | Frame ended as seen by the framing logic |
| count_o | output | CNT_W | Current count (reads 0 when READ_EN = 0) |
| en_o | output | 1 | Counter enabled |
| eof_tag_o | output | 1 | End tag for the character strobed in this cycle |
| resid_o | output | CNT_W | Count left over when the frame ended early |
| resid_vld_o | output | 1 | `resid_o` holds a captured value |

## Verification
The bench aims at the last step of the count and at what follows it.
- A design that tags on terminal count instead of on the 1-to-0 step would tag one character too late, or would keep tagging at zero.
- A design that wraps would jump to all ones.
- A design that lets a strobe beat a load would start the new frame one character short.
- A design that does not gate on the limit would start counting from a zero limit.
- A design that decodes the purge command would clear the count.
- A design that gets the early-end capture wrong would store a count that has already been decremented.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_LOAD  = 2'b01,
    CMD_CLEAR = 2'b10,
    CMD_PURGE = 2'b11
  } cmd_e;
endpackage

// File: rtl/fcc_limit_reg.sv
module fcc_limit_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] limit_o,
  output logic         nz_o
);
  logic [W-1:0] limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   limit_q <= '0;
    else if (we_i) limit_q <= wdata_i;
  end

  assign limit_o = limit_q;
  assign nz_o    = |limit_q;

  // R1
  limit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(limit_q));
endmodule

// File: rtl/fcc_down_cnt.sv
module fcc_down_cnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic         clr_i,
  input  logic         stb_i,
  input  logic [W-1:0] limit_i,
  input  logic         limit_nz_i,
  output logic [W-1:0] cnt_o,
  output logic         en_o,
  output logic         tag_o
);
  logic [W-1:0] cnt_q;
  logic         en_q;
  logic         dec;

  assign dec = stb_i && en_q && (cnt_q != '0) && !ld_i && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (ld_i) begin
      cnt_q <= limit_i;
      en_q  <= limit_nz_i;
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // marks the exact character that steps the count from 1 to 0
  assign tag_o = dec && (cnt_q == W'(1));
  assign cnt_o = cnt_q;
  assign en_o  = en_q;

  // R1
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> (cnt_q == $past(limit_i)));
  // R2
  zero_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i && limit_i == '0) |=> !en_q);
  // R3
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && en_q && cnt_q != '0 && !ld_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R4
  tag_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_o |=> (cnt_q == '0));
  // R5
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !ld_i) |=> (cnt_q == '0));
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !en_q));
endmodule

// File: rtl/fcc_resid_hold.sv
module fcc_resid_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         end_i,
  input  logic         en_i,
  input  logic [W-1:0] cnt_i,
  input  logic         rel_i,
  output logic [W-1:0] resid_o,
  output logic         vld_o
);
  logic [W-1:0] resid_q;
  logic         vld_q;
  logic         cap;

  assign cap = end_i && en_i && (cnt_i != '0) && !rel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resid_q <= '0;
      vld_q   <= 1'b0;
    end else if (rel_i) begin
      vld_q   <= 1'b0;
    end else if (cap) begin
      resid_q <= cnt_i;
      vld_q   <= 1'b1;
    end
  end

  assign resid_o = resid_q;
  assign vld_o   = vld_q;

  // R8
  resid_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && en_i && cnt_i != '0 && !rel_i) |=> (vld_q && resid_q == $past(cnt_i)));
  // R8
  resid_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> !vld_q);
endmodule

// File: rtl/frame_char_counter.sv
module frame_char_counter #(
  parameter int unsigned CNT_W   = 8,
  parameter bit          READ_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_wdata_i,
  input  logic [1:0]       cmd_i,
  input  logic             frame_start_i,
  input  logic             char_stb_i,
  input  logic             frame_end_i,
  output logic [CNT_W-1:0] count_o,
  output logic             en_o,
  output logic             eof_tag_o,
  output logic [CNT_W-1:0] resid_o,
  output logic             resid_vld_o
);
  import fcc_pkg::*;

  cmd_e             cmd;
  logic             ld, clr;
  logic [CNT_W-1:0] limit, cnt;
  logic             limit_nz, en;

  assign cmd = cmd_e'(cmd_i);
  assign ld  = frame_start_i || (cmd == CMD_LOAD);
  assign clr = (cmd == CMD_CLEAR);  // purge deliberately not decoded

  fcc_limit_reg #(.W(CNT_W)) u_lim (
    .clk_i, .rst_ni, .we_i(lim_we_i), .wdata_i(lim_wdata_i),
    .limit_o(limit), .nz_o(limit_nz)
  );

  fcc_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .ld_i(ld), .clr_i(clr), .stb_i(char_stb_i),
    .limit_i(limit), .limit_nz_i(limit_nz),
    .cnt_o(cnt), .en_o(en), .tag_o(eof_tag_o)
  );

  fcc_resid_hold #(.W(CNT_W)) u_res (
    .clk_i, .rst_ni, .end_i(frame_end_i), .en_i(en), .cnt_i(cnt),
    .rel_i(ld || clr), .resid_o, .vld_o(resid_vld_o)
  );

  assign en_o = en;

  generate
    if (READ_EN) begin : g_rd
      assign count_o = cnt;
    end else begin : g_hide
      assign count_o = '0;
    end
  endgenerate

  // R7
  purge_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_PURGE && !frame_start_i && !char_stb_i) |=> ($stable(cnt) && $stable(en)));
endmodule

// File: tb/sim_frame_char_counter.sv
`timescale 1ns/1ps
module sim_frame_char_counter;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lim_we = 1'b0;
  logic [W-1:0] lim_wd = '0;
  logic [1:0]   cmd = 2'b00;
  logic         fs = 1'b0, stb = 1'b0, fe = 1'b0;
  logic [W-1:0] count, resid, count1, resid1;
  logic         en, tag, rvld, en1, tag1, rvld1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic tag_s;

  always #4 clk = ~clk;

  frame_char_counter #(.CNT_W(W), .READ_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lim_we_i(lim_we), .lim_wdata_i(lim_wd),
    .cmd_i(cmd), .frame_start_i(fs), .char_stb_i(stb), .frame_end_i(fe),
    .count_o(count), .en_o(en), .eof_tag_o(tag), .resid_o(resid), .resid_vld_o(rvld));

  frame_char_counter #(.CNT_W(W), .READ_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .lim_we_i(lim_we), .lim_wdata_i(lim_wd),
    .cmd_i(cmd), .frame_start_i(fs), .char_stb_i(stb), .frame_end_i(fe),
    .count_o(count1), .en_o(en1), .eof_tag_o(tag1), .resid_o(resid1), .resid_vld_o(rvld1));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample tag before the edge, registers after it
  task automatic cyc(bit l, bit s, bit e, logic [1:0] c);
    @(negedge clk);
    fs = l; stb = s; fe = e; cmd = c; lim_we = 1'b0;
    #1 tag_s = tag;
    @(posedge clk); #1;
  endtask

  task automatic wr_lim(logic [W-1:0] v);
    @(negedge clk);
    lim_we = 1'b1; lim_wd = v; fs = 0; stb = 0; fe = 0; cmd = 2'b00;
    @(posedge clk); #1;
  endtask

  // {load, strobe, expected tag, expected count after edge}
  localparam logic [10:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 8'd3},
    {1'b0, 1'b1, 1'b0, 8'd2},
    {1'b0, 1'b1, 1'b0, 8'd1},
    {1'b1, 1'b1, 1'b0, 8'd3},
    {1'b0, 1'b1, 1'b0, 8'd2},
    {1'b0, 1'b1, 1'b0, 8'd1},
    {1'b0, 1'b1, 1'b1, 8'd0},
    {1'b0, 1'b1, 1'b0, 8'd0}
  };

  initial begin
    #100000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #3;
    // R10 reset state
    chk("R10 count", count, 0);
    chk("R10 en", en, 0);
    chk("R10 tag", tag, 0);
    chk("R10 resid_vld", rvld, 0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;

    wr_lim(8'd3);
    // R3 R4 R5 R6 vector walk
    for (int i = 0; i < 8; i++) begin
      cyc(VEC[i][10], VEC[i][9], 1'b0, 2'b00);
      chk($sformatf("R3 R4 R5 R6 tag vec %0d", i), tag_s, VEC[i][8]);
      chk($sformatf("R3 R5 R6 count vec %0d", i), count, VEC[i][7:0]);
    end
    cyc(0, 0, 0, 2'b00);

    // R1 command load path
    wr_lim(8'd9);
    cyc(0, 0, 0, 2'b01);
    chk("R1 cmd load count", count, 9);
    chk("R2 enabled", en, 1);

    // R7 purge keeps, clear zeroes
    cyc(0, 0, 0, 2'b11);
    chk("R7 purge count", count, 9);
    chk("R7 purge en", en, 1);
    cyc(0, 0, 0, 2'b10);
    chk("R7 clear count", count, 0);
    chk("R7 clear en", en, 0);

    // R2 zero limit leaves counter off
    wr_lim(8'd0);
    cyc(1, 0, 0, 2'b00);
    chk("R2 zero limit en", en, 0);
    cyc(0, 1, 0, 2'b00);
    chk("R2 zero limit tag", tag_s, 0);
    chk("R2 zero limit count", count, 0);

    // R8 early frame end capture
    wr_lim(8'd5);
    cyc(1, 0, 0, 2'b00);
    cyc(0, 1, 0, 2'b00);
    cyc(0, 1, 0, 2'b00);
    chk("R3 count before end", count, 3);
    cyc(0, 1, 1, 2'b00);
    chk("R8 resid value", resid, 3);
    chk("R8 resid valid", rvld, 1);
    // R9 hidden receive count, residual still works
    chk("R9 hidden count", count1, 0);
    chk("R9 hidden en", en1, 1);
    chk("R9 hidden resid", resid1, 3);
    cyc(1, 0, 0, 2'b00);
    chk("R8 resid released", rvld, 0);
    chk("R1 reload count", count, 5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule